// File: doc/BRIEF.md
# I2C Master Byte Transmitter

This block is the transmit half of an I2C bus master, driven by a small processor-style register interface. Software asks for a start condition through a control write, loads the slave address together with the read/write bit into a one-byte data register, and then supplies data bytes one at a time. Each byte goes out on eight SCL clocks, most significant bit first. On the ninth clock the block releases SDA, samples the acknowledge from the slave, and raises a transfer-complete flag.

After each byte the block keeps SCL low. The next byte leaves only when software has loaded the data register and also cleared the flag, in either order. If software writes a stop request instead, the block releases SDA while SCL is high and returns to the idle bus. SCL and SDA are open-drain. The block drives a pull-low enable for each line and reads the SDA line level back in.

SCL timing comes from a free-running divider. Each bit takes four quarter-periods of `QDIV` system clocks. SCL is low for the first two quarters and high for the last two. SDA changes only at the start of a low phase, except during start and stop conditions.

Top module: `i2c_tx_master`

## Requirements
- R1: After reset `bus_idle` is 1, `irq_flag` is 0, `ack_stat` is 0, and neither line is pulled low.
- R2: A control write with `cr_busy`=1 and `cr_ctl`=0 while idle creates a start condition: SDA falls while SCL is high. `bus_idle` then goes to 0, and SCL is held low until a byte is loaded.
- R3: A byte is sent on eight SCL pulses, bit 7 first. SDA is released during the ninth pulse. Inside a byte, SDA does not change while SCL is high.
- R4: `irq_flag` goes to 1 in the same clock cycle in which SCL rises for the ninth pulse of a byte.
- R5: `ack_stat` holds the SDA level sampled at the ninth pulse: 0 means the slave acknowledged, 1 means no acknowledge. It is updated together with the flag.
- R6: After the ninth pulse, SCL stays low until both a data register write and a flag clear have happened, in either order.
- R7: `irq_flag` stays 1 until a `flag_clr` pulse. If a clear and a set fall in the same cycle, the flag ends up 1.
- R8: Data register writes made while the address byte is being sent, from its first pulse until its ninth pulse ends, are ignored.
- R9: A control write with `cr_busy`=0 and `cr_ctl`=0 during a transfer creates a stop once the current byte ends: SDA rises while SCL is high, then `bus_idle` returns to 1 and both lines are released. A stop wins over a byte that becomes ready in the same cycle, and that byte is discarded.
- R10: Control writes with `cr_ctl`=1 create neither a start nor a stop.
- R11: Each SCL pulse within a byte is high for 2*`QDIV` system clocks and low for 2*`QDIV` system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dr_wr | input | 1 | Data register write strobe |
| dr_wdata | input | BYTE_W | Byte to transmit (the address byte includes the R/W bit in bit 0) |
| cr_wr | input | 1 | Control write strobe |
| cr_busy | input | 1 | Bus-busy bit of the control write |
| cr_ctl | input | 1 | Start/stop control bit of the control write (0 requests a condition) |
| flag_clr | input | 1 | Clears the transfer-complete flag |
| sda_in | input | 1 | Sensed SDA line level |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| irq_flag | output | 1 | Transfer-complete flag |
| ack_stat | output | 1 | Acknowledge level sampled at the ninth pulse |
| bus_idle | output | 1 | 1 when no start has been issued since the last stop |

## Verification
The hardest case to reach is a flag clear that lands in exactly the cycle when the ninth pulse sets the flag. From the ports, the bench cannot predict that cycle to the clock. So it raises `flag_clr` right after the eighth falling edge, holds it through the ninth rise, and lowers it at the first sample where the flag is seen high. A design that lets the clear win would never show the flag and would stall.

The ignored-write window is reached with a forked process. It waits for the first SCL rise of the address byte and writes a different byte at that point. The bench then clears the flag without a new write and confirms that SCL stays parked low.

// File: rtl/i2c_tx_pkg.sv
package i2c_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_HOLD,
    ST_BIT,
    ST_STOP
  } txst_e;

  // SCL is low in quarters 0 and 1 of a bit, high in quarters 2 and 3
  function automatic logic drive_scl_low(input txst_e s, input logic [1:0] q);
    case (s)
      ST_HOLD:         return 1'b1;
      ST_BIT, ST_STOP: return ~q[1];
      default:         return 1'b0;
    endcase
  endfunction

  // data_slot: 1 for clocks 1..8, 0 for the acknowledge slot
  function automatic logic drive_sda_low(input txst_e s, input logic [1:0] q,
                                         input logic data_slot, input logic msb,
                                         input logic park_low);
    case (s)
      ST_START: return q[1];
      ST_HOLD:  return park_low;
      ST_BIT:   return data_slot & ~msb;
      ST_STOP:  return (q != 2'd3);
      default:  return 1'b0;
    endcase
  endfunction

  // the edge where SCL rises inside a bit is the end of quarter 1
  function automatic logic is_rise_quarter(input logic [1:0] q);
    return (q == 2'd1);
  endfunction

endpackage

// File: rtl/i2c_tx_tick.sv
module i2c_tx_tick #(
  parameter int unsigned QDIV = 25
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (QDIV > 2) ? $clog2(QDIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + CW'(1);
  end

  assign tick = (cnt == LAST);

  // R11
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick)
    else $error("quarter tick fired on consecutive cycles");

endmodule

// File: rtl/i2c_tx_regs.sv
module i2c_tx_regs #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dr_wr,
  input  logic [BYTE_W-1:0] dr_wdata,
  input  logic              cr_wr,
  input  logic              cr_busy,
  input  logic              cr_ctl,
  input  logic              flag_clr,
  input  logic              idle,
  input  logic              start_take,
  input  logic              stop_take,
  input  logic              load,
  input  logic              flag_set,
  input  logic              ack_val,
  input  logic              addr_busy,
  output logic [BYTE_W-1:0] dr_q,
  output logic              dr_full,
  output logic              flag,
  output logic              ack_q,
  output logic              start_pend,
  output logic              stop_pend
);
  logic wr_ok, start_req, stop_req;

  assign wr_ok     = dr_wr & ~addr_busy;
  assign start_req = cr_wr &  cr_busy & ~cr_ctl;
  assign stop_req  = cr_wr & ~cr_busy & ~cr_ctl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr_q    <= '0;
      dr_full <= 1'b0;
    end else if (wr_ok) begin
      dr_q    <= dr_wdata;
      dr_full <= 1'b1;
    end else if (load || stop_take) begin
      dr_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_pend <= 1'b0;
      stop_pend  <= 1'b0;
    end else begin
      if (start_take) start_pend <= 1'b0;
      else if (start_req && idle) start_pend <= 1'b1;
      if (stop_take) stop_pend <= 1'b0;
      else if (stop_req && !idle) stop_pend <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      if (flag_set) flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
      if (flag_set) ack_q <= ack_val;
    end
  end

  // R7
  flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set |=> flag)
    else $error("flag not set after completion event");

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !flag_set) |=> !flag)
    else $error("flag survived a clear");

  // R8
  addr_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_wr && addr_busy) |=> $stable(dr_q))
    else $error("data register changed during address byte");

endmodule

// File: rtl/i2c_tx_seq.sv
module i2c_tx_seq
  import i2c_tx_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start_pend,
  input  logic              stop_pend,
  input  logic              dr_full,
  input  logic              flag,
  input  logic [BYTE_W-1:0] dr,
  input  logic              sda_in,
  output logic              scl_low,
  output logic              sda_low,
  output logic              idle,
  output logic              start_take,
  output logic              stop_take,
  output logic              load,
  output logic              flag_set,
  output logic              ack_val,
  output logic              addr_busy
);
  localparam int unsigned IDX_W = $clog2(BYTE_W + 1);
  localparam logic [IDX_W-1:0] ACK_IDX = IDX_W'(BYTE_W);

  txst_e             st;
  logic [1:0]        q;
  logic [IDX_W-1:0]  idx;
  logic [BYTE_W-1:0] shreg;
  logic              park_low;
  logic              addr_phase;
  logic              ack_slot;

  assign ack_slot   = (idx == ACK_IDX);
  assign idle       = (st == ST_IDLE);
  assign start_take = tick && (st == ST_IDLE) && start_pend;
  assign stop_take  = tick && (st == ST_HOLD) && stop_pend;
  assign load       = tick && (st == ST_HOLD) && !stop_pend && dr_full && !flag;
  assign flag_set   = tick && (st == ST_BIT) && ack_slot && is_rise_quarter(q);
  assign ack_val    = sda_in;
  assign addr_busy  = addr_phase && (st == ST_BIT);

  assign scl_low = drive_scl_low(st, q);
  assign sda_low = drive_sda_low(st, q, ~ack_slot, shreg[BYTE_W-1], park_low);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      q          <= 2'd0;
      idx        <= '0;
      shreg      <= '0;
      park_low   <= 1'b0;
      addr_phase <= 1'b0;
    end else if (tick) begin
      case (st)
        ST_IDLE: begin
          if (start_pend) begin
            st <= ST_START;
            q  <= 2'd0;
          end
        end
        ST_START: begin
          q <= q + 2'd1;
          if (q == 2'd3) begin
            st         <= ST_HOLD;
            park_low   <= 1'b1;
            addr_phase <= 1'b1;
          end
        end
        ST_HOLD: begin
          if (stop_pend) begin
            st <= ST_STOP;
            q  <= 2'd0;
          end else if (dr_full && !flag) begin
            st    <= ST_BIT;
            q     <= 2'd0;
            idx   <= '0;
            shreg <= dr;
          end
        end
        ST_BIT: begin
          q <= q + 2'd1;
          if (q == 2'd3) begin
            if (ack_slot) begin
              st         <= ST_HOLD;
              park_low   <= 1'b0;
              addr_phase <= 1'b0;
            end else begin
              idx   <= idx + IDX_W'(1);
              shreg <= {shreg[BYTE_W-2:0], 1'b0};
            end
          end
        end
        ST_STOP: begin
          q <= q + 2'd1;
          if (q == 2'd3) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3
  sda_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BIT && $past(st) == ST_BIT && !scl_low && !$past(scl_low))
      |-> $stable(sda_low))
    else $error("SDA moved while SCL high inside a byte");

  // R3
  ack_slot_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BIT && ack_slot) |-> !sda_low)
    else $error("master drove SDA in the acknowledge slot");

endmodule

// File: rtl/i2c_tx_master.sv
module i2c_tx_master #(
  parameter int unsigned QDIV   = 25,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dr_wr,
  input  logic [BYTE_W-1:0] dr_wdata,
  input  logic              cr_wr,
  input  logic              cr_busy,
  input  logic              cr_ctl,
  input  logic              flag_clr,
  input  logic              sda_in,
  output logic              scl_pull,
  output logic              sda_pull,
  output logic              irq_flag,
  output logic              ack_stat,
  output logic              bus_idle
);
  logic              tick;
  logic              start_take, stop_take, load, flag_set, ack_val, addr_busy;
  logic [BYTE_W-1:0] dr_q;
  logic              dr_full, start_pend, stop_pend;

  i2c_tx_tick #(.QDIV(QDIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  i2c_tx_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .dr_wr     (dr_wr),
    .dr_wdata  (dr_wdata),
    .cr_wr     (cr_wr),
    .cr_busy   (cr_busy),
    .cr_ctl    (cr_ctl),
    .flag_clr  (flag_clr),
    .idle      (bus_idle),
    .start_take(start_take),
    .stop_take (stop_take),
    .load      (load),
    .flag_set  (flag_set),
    .ack_val   (ack_val),
    .addr_busy (addr_busy),
    .dr_q      (dr_q),
    .dr_full   (dr_full),
    .flag      (irq_flag),
    .ack_q     (ack_stat),
    .start_pend(start_pend),
    .stop_pend (stop_pend)
  );

  i2c_tx_seq #(.BYTE_W(BYTE_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .start_pend(start_pend),
    .stop_pend (stop_pend),
    .dr_full   (dr_full),
    .flag      (irq_flag),
    .dr        (dr_q),
    .sda_in    (sda_in),
    .scl_low   (scl_pull),
    .sda_low   (sda_pull),
    .idle      (bus_idle),
    .start_take(start_take),
    .stop_take (stop_take),
    .load      (load),
    .flag_set  (flag_set),
    .ack_val   (ack_val),
    .addr_busy (addr_busy)
  );

  // R4
  flag_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $fell(scl_pull))
    else $error("flag rose without the ninth SCL rise");

  // R5
  ack_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> (ack_stat == $past(sda_in)))
    else $error("ack status does not match sampled SDA");

  // R2
  start_leaves_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_take |=> !bus_idle)
    else $error("idle still set after start accepted");

  // R6
  tx_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!irq_flag && dr_full))
    else $error("byte launched with flag set or no data");

endmodule

// File: tb/tb_i2c_tx_master.sv
module tb_i2c_tx_master;
  localparam int unsigned QDIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dr_wr = 1'b0;
  logic [7:0] dr_wdata = 8'h00;
  logic       cr_wr = 1'b0, cr_busy = 1'b0, cr_ctl = 1'b0, flag_clr = 1'b0;
  logic       slave_low = 1'b0;
  wire        scl_pull, sda_pull, irq_flag, ack_stat, bus_idle;
  wire        sda_line = !(sda_pull || slave_low);
  wire        scl_line = !scl_pull;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  i2c_tx_master #(.QDIV(QDIV), .BYTE_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .dr_wr(dr_wr), .dr_wdata(dr_wdata),
    .cr_wr(cr_wr), .cr_busy(cr_busy), .cr_ctl(cr_ctl), .flag_clr(flag_clr),
    .sda_in(sda_line), .scl_pull(scl_pull), .sda_pull(sda_pull),
    .irq_flag(irq_flag), .ack_stat(ack_stat), .bus_idle(bus_idle)
  );

  // {nack_from_slave, byte}: entry 0 is the address byte
  localparam logic [8:0] VEC [5] = '{9'h0A4, 9'h05A, 9'h0FF, 9'h100, 9'h081};

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cpu(input bit wd, input logic [7:0] d, input bit clr,
                     input bit wc, input bit busy, input bit ctl);
    @(negedge clk);
    dr_wr = wd; dr_wdata = d; flag_clr = clr;
    cr_wr = wc; cr_busy = busy; cr_ctl = ctl;
    @(negedge clk);
    dr_wr = 0; flag_clr = 0; cr_wr = 0;
  endtask

  task automatic wait_start();
    logic ps;
    ps = sda_line;
    @(negedge clk);
    while (!(ps && !sda_line && scl_line)) begin
      ps = sda_line;
      @(negedge clk);
    end
  endtask

  task automatic wait_stop(output int rises);
    logic ps, pc;
    rises = 0;
    ps = sda_line; pc = scl_line;
    @(negedge clk);
    while (!(!ps && sda_line && scl_line)) begin
      if (!pc && scl_line) rises++;
      ps = sda_line; pc = scl_line;
      @(negedge clk);
    end
    if (!pc && scl_line) rises++;
  endtask

  task automatic hold_low(input int n, input string tag);
    int lows = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (!scl_line) lows++;
    end
    check(tag, lows, n);
  endtask

  task automatic recv_byte(input logic nack, input bit hold_clr,
                           output logic [7:0] got, output int hi0,
                           output bit flag_ok, output bit stable_ok);
    logic v;
    int hi;
    got = 8'h00; flag_ok = 0; stable_ok = 1; hi0 = 0;
    for (int b = 0; b < 9; b++) begin
      if (b == 8) begin
        slave_low = !nack;
        if (hold_clr) flag_clr = 1;
      end
      @(negedge clk);
      while (!scl_line) begin
        if (b < 8 && irq_flag) flag_ok = 0;
        @(negedge clk);
      end
      if (b == 8) begin
        flag_ok = irq_flag;
        flag_clr = 0;
      end
      v = sda_line;
      if (b < 8) got = {got[6:0], v};
      hi = 0;
      while (scl_line) begin
        hi++;
        if (sda_line !== v) stable_ok = 0;
        @(negedge clk);
      end
      if (b == 0) hi0 = hi;
      if (b == 8) slave_low = 0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] got;
    int hi, rises;
    bit fok, sok;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check("R1 idle", bus_idle, 1);
    check("R1 flag", irq_flag, 0);
    check("R1 ack", ack_stat, 0);
    check("R1 lines", {scl_line, sda_line}, 2'b11);

    // table-driven transfer
    for (int i = 0; i < 5; i++) begin
      if (i == 0) begin
        cpu(0, 8'h00, 0, 1, 1, 0);
        wait_start();
        // R2
        check("R2 idle cleared", bus_idle, 0);
        while (scl_line) @(negedge clk);
        hold_low(20, "R2 SCL parked after start");
        cpu(1, VEC[i][7:0], 0, 0, 0, 0);
      end else if (i % 2 == 1) begin
        cpu(1, VEC[i][7:0], 0, 0, 0, 0);
        hold_low(40, "R6 data written, flag still set");
        cpu(0, 8'h00, 1, 0, 0, 0);
      end else begin
        cpu(0, 8'h00, 1, 0, 0, 0);
        hold_low(40, "R6 flag cleared, no data");
        cpu(1, VEC[i][7:0], 0, 0, 0, 0);
      end
      recv_byte(VEC[i][8], (i == 2), got, hi, fok, sok);
      check("R3 byte value", got, VEC[i][7:0]);
      check("R3 SDA stable while SCL high", sok, 1);
      check("R4 flag at ninth rise", fok, 1);
      check("R11 SCL high time", hi, 2 * QDIV);
      @(negedge clk);
      check("R5 ack status", ack_stat, VEC[i][8]);
      if (i == 2) begin
        repeat (5) @(negedge clk);
        check("R7 flag kept after same-cycle clear", irq_flag, 1);
      end
    end

    // R9 stop wins over a byte ready in the same cycle
    cpu(1, 8'h11, 1, 1, 0, 0);
    wait_stop(rises);
    check("R9 no byte before stop", rises, 1);
    repeat (8) @(negedge clk);
    check("R9 idle after stop", bus_idle, 1);
    check("R9 lines released", {scl_line, sda_line}, 2'b11);

    // R10 control write with ctl=1 does nothing
    cpu(0, 8'h00, 0, 1, 1, 1);
    begin
      int bad = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (!scl_line || !sda_line || !bus_idle) bad++;
      end
      check("R10 no condition", bad, 0);
    end

    // R8 write during address byte ignored; R9 discarded data
    cpu(0, 8'h00, 0, 1, 1, 0);
    wait_start();
    while (scl_line) @(negedge clk);
    hold_low(40, "R9 discarded byte not sent");
    cpu(1, 8'h3C, 0, 0, 0, 0);
    fork
      recv_byte(1'b0, 0, got, hi, fok, sok);
      begin
        @(negedge clk);
        while (!scl_line) @(negedge clk);
        cpu(1, 8'h99, 0, 0, 0, 0);
      end
    join
    check("R8 address byte", got, 8'h3C);
    cpu(0, 8'h00, 1, 0, 0, 0);
    hold_low(40, "R8 write in address byte ignored");
    cpu(1, 8'h66, 0, 0, 0, 0);
    recv_byte(1'b1, 0, got, hi, fok, sok);
    check("R8 next byte", got, 8'h66);
    check("R7 flag held", irq_flag, 1);
    @(negedge clk);
    check("R5 nack seen", ack_stat, 1);
    cpu(0, 8'h00, 1, 1, 0, 0);
    check("R7 flag cleared", irq_flag, 0);
    wait_stop(rises);
    repeat (8) @(negedge clk);
    check("R9 idle at end", bus_idle, 1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule